// File: doc/BRIEF.md
# Program Sequence Tracker for a NAND Device Front End

This block sits on the device side of a NAND interface, after the pin layer has turned each latch strobe into one cycle record. Every record carries a kind (command, address or data) and a byte. The block follows the program family of sequences. A setup code opens a sequence. An internal-data-input code can retarget a pending program to a new row and column while the cache contents stay in place. One of three confirm codes closes the sequence. Along the way the block assembles the column and row from the address bytes, keeps a running column pointer and emits one cache-buffer write per data byte.

The cycle records enter over a valid/ready handshake, and the cache writes leave over a second one. The write port is a single register stage. When that register is full and the cache does not take it, `in_ready` falls, so no cycle of any kind is taken until the held write drains. A held write keeps its column and byte unchanged until `wr_ready` is seen high. Status pins are plain levels or pulses: a one-cycle completion pulse with its program kind, a sticky sequence-error flag, and a sticky flag for a retarget whose die or plane bits did not match the pending sequence.

Top module: `nps_pgm_seq`

## Requirements
- R1: A cycle record is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_kind` is 0 for a command, 1 for an address and 2 for a data byte. While `wr_valid` is high and `wr_ready` is low, `in_ready` is low, and `wr_col` and `wr_data` hold their values.
- R2: Command 80h, given with `rdy` high, opens address collection and clears any pending program. Five address bytes follow: column low byte, column high byte, then the row in three bytes, least significant first. After the fifth byte `data_mode` rises, `col_ptr` equals the column and `tgt_row` equals the row.
- R3: A data byte taken in data mode produces a write on the next cycle, with `wr_col` set to the old `col_ptr` and `wr_data` set to the byte. `col_ptr` then advances by one.
- R4: The column pointer stops at 2112, which is the page bytes plus the spare bytes, and a loaded column above that value is clamped to 2112. A data byte taken with the pointer at 2112 makes no write and raises no error.
- R5: A confirm of 10h, 11h or 15h while a program is pending with its address complete gives a one-cycle `done_valid` pulse. `done_kind` is 1, 2 or 3 respectively. The confirm clears data mode and the pending program.
- R6: Command 85h inside a pending program reads five address bytes. If row bit 23 (die) and row bit 6 (plane) match the pending row, `tgt_row` and `col_ptr` take the new values and data mode resumes.
- R7: If those bits differ, `lun_err` sets and stays set. `tgt_row` and `col_ptr` keep their earlier values, and data mode resumes at the old pointer.
- R8: Command 85h with no program pending opens a new program without the die and plane check, and a later confirm completes it.
- R9: Command 80h or 85h taken while `rdy` is low is rejected. `seq_err` sets, and data mode and `col_ptr` are left as they were.
- R10: The non-program commands 00h, 05h, 06h, 30h, 35h, 70h, 78h, 90h, E0h, ECh, EEh and EFh end data mode but keep the pending program, so it can still be confirmed.
- R11: `seq_err` sets and stays set on any of these: an unknown command code, a confirm with no pending program, a data byte outside data mode (which makes no write), an address byte outside collection, or `in_kind` equal to 3.
- R12: Reset, or command FFh, clears both error flags, data mode and the pending program, and sets `col_ptr` and `tgt_row` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy | input | 1 | Device ready level; setup and retarget codes need it high |
| in_valid | input | 1 | Cycle record valid |
| in_ready | output | 1 | Cycle record can be taken |
| in_kind | input | 2 | 0 command, 1 address, 2 data, 3 illegal |
| in_byte | input | 8 | Command code, address byte or data byte |
| wr_valid | output | 1 | Cache write pending |
| wr_ready | input | 1 | Cache takes the pending write |
| wr_col | output | 12 | Column of the cache write |
| wr_data | output | 8 | Byte of the cache write |
| col_ptr | output | 12 | Current column pointer |
| tgt_row | output | 24 | Target row of the pending program |
| data_mode | output | 1 | Data bytes are accepted |
| done_valid | output | 1 | One-cycle completion pulse |
| done_kind | output | 2 | 1 single page, 2 two-plane, 3 cache program |
| seq_err | output | 1 | Sticky sequence violation |
| lun_err | output | 1 | Sticky die or plane mismatch on retarget |

## Verification
A wrong address-byte count shows up on the edge after the fifth address byte. At that point `data_mode` either stays low or `tgt_row` carries shifted bytes. A stale pending bit shows at the next confirm, as a missing `done_valid` or a `seq_err` that should not be there. A pointer off by one, or a bad clamp, appears in the very first `wr_col` after a load. Errors in the die and plane comparison show on the cycle after a retarget completes: `lun_err`, `tgt_row` and `col_ptr` move together, so each directed case compares all three at once.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_DATA = 2'd2,
    CYC_BAD  = 2'd3
  } cyc_kind_e;

  typedef enum logic [2:0] {
    CC_SETUP,
    CC_MOVE,
    CC_CONFIRM,
    CC_RESET,
    CC_OTHER,
    CC_UNKNOWN
  } cmd_cls_e;

  localparam logic [7:0] OP_SETUP   = 8'h80;
  localparam logic [7:0] OP_MOVE    = 8'h85;
  localparam logic [7:0] OP_CONF_SP = 8'h10;
  localparam logic [7:0] OP_CONF_TP = 8'h11;
  localparam logic [7:0] OP_CONF_CP = 8'h15;
  localparam logic [7:0] OP_RESET   = 8'hFF;

  localparam logic [1:0] KIND_SINGLE   = 2'd1;
  localparam logic [1:0] KIND_TWOPLANE = 2'd2;
  localparam logic [1:0] KIND_CACHE    = 2'd3;
endpackage

// File: rtl/nps_cmd_decode.sv
module nps_cmd_decode
  import nps_pkg::*;
(
  input  logic [7:0] code,
  output cmd_cls_e   cls,
  output logic [1:0] kind
);
  always_comb begin
    kind = 2'd0;
    unique case (code)
      OP_SETUP:   cls = CC_SETUP;
      OP_MOVE:    cls = CC_MOVE;
      OP_RESET:   cls = CC_RESET;
      OP_CONF_SP: begin cls = CC_CONFIRM; kind = KIND_SINGLE;   end
      OP_CONF_TP: begin cls = CC_CONFIRM; kind = KIND_TWOPLANE; end
      OP_CONF_CP: begin cls = CC_CONFIRM; kind = KIND_CACHE;    end
      8'h00, 8'h05, 8'h06, 8'h30, 8'h35, 8'h70,
      8'h78, 8'h90, 8'hE0, 8'hEC, 8'hEE, 8'hEF:
                  cls = CC_OTHER;
      default:    cls = CC_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/nps_addr_asm.sv
module nps_addr_asm #(
  parameter int COL_W = 12,
  parameter int ROW_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             fire,
  input  logic [7:0]       byte_i,
  output logic             collecting,
  output logic             done,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row
);
  localparam int COL_CYC = (COL_W + 7) / 8;
  localparam int ROW_CYC = (ROW_W + 7) / 8;
  localparam int TOT     = COL_CYC + ROW_CYC;
  localparam int CNT_W   = $clog2(TOT);
  localparam int ALL_W   = 8 * TOT;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOT - 1);

  logic [CNT_W-1:0] cnt;
  logic [ALL_W-1:0] shadow;
  logic [ALL_W-1:0] merged;

  // the byte being taken this cycle is merged in, so the result is
  // available on the same edge as the final address byte
  for (genvar g = 0; g < TOT; g++) begin : g_byte
    assign merged[8*g +: 8] = (cnt == CNT_W'(g)) ? byte_i : shadow[8*g +: 8];
  end

  assign done = fire && collecting && (cnt == LAST);
  assign col  = COL_W'(merged[8*COL_CYC-1:0]);
  assign row  = ROW_W'(merged[ALL_W-1:8*COL_CYC]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      collecting <= 1'b0;
      cnt        <= '0;
      shadow     <= '0;
    end else if (start) begin
      collecting <= 1'b1;
      cnt        <= '0;
    end else if (abort) begin
      collecting <= 1'b0;
      cnt        <= '0;
    end else if (fire && collecting) begin
      shadow[8*cnt +: 8] <= byte_i;
      if (cnt == LAST) begin
        collecting <= 1'b0;
        cnt        <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nps_wr_stage.sv
module nps_wr_stage #(
  parameter int COL_W   = 12,
  parameter int COL_MAX = 2112
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [COL_W-1:0] load_col,
  input  logic             dat_fire,
  input  logic [7:0]       dat,
  input  logic             wr_ready,
  output logic [COL_W-1:0] ptr,
  output logic             wr_valid,
  output logic [COL_W-1:0] wr_col,
  output logic [7:0]       wr_data
);
  localparam logic [COL_W-1:0] LIM = COL_W'(COL_MAX);

  logic             room;
  logic [COL_W-1:0] load_clamped;

  assign room         = (ptr != LIM);
  assign load_clamped = (load_col > LIM) ? LIM : load_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (clear) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_clamped;
    end else if (dat_fire && room) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_col   <= '0;
      wr_data  <= '0;
    end else if (dat_fire && room) begin
      wr_valid <= 1'b1;
      wr_col   <= ptr;
      wr_data  <= dat;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nps_pgm_seq.sv
module nps_pgm_seq
  import nps_pkg::*;
#(
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int ROW_W       = 24,
  parameter int PAGE_W      = 6,
  parameter int LUN_W       = 1,
  localparam int COL_MAX    = PAGE_BYTES + SPARE_BYTES,
  localparam int COL_W      = $clog2(COL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdy,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [7:0]       in_byte,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [COL_W-1:0] wr_col,
  output logic [7:0]       wr_data,
  output logic [COL_W-1:0] col_ptr,
  output logic [ROW_W-1:0] tgt_row,
  output logic             data_mode,
  output logic             done_valid,
  output logic [1:0]       done_kind,
  output logic             seq_err,
  output logic             lun_err
);
  localparam int PLANE_POS = PAGE_W;
  localparam int LUN_POS   = ROW_W - LUN_W;

  logic             fire, cmd_fire, addr_fire, data_fire, bad_fire;
  cmd_cls_e         cls;
  logic [1:0]       conf_kind;
  logic             pend, chk;
  logic             asm_start, asm_abort, collecting, asm_done;
  logic [COL_W-1:0] asm_col;
  logic [ROW_W-1:0] asm_row;
  logic             mismatch, accept_addr, clear_all;

  assign in_ready  = !wr_valid || wr_ready;
  assign fire      = in_valid && in_ready;
  assign cmd_fire  = fire && (in_kind == CYC_CMD);
  assign addr_fire = fire && (in_kind == CYC_ADDR);
  assign data_fire = fire && (in_kind == CYC_DATA);
  assign bad_fire  = fire && (in_kind == CYC_BAD);

  nps_cmd_decode u_dec (
    .code (in_byte),
    .cls  (cls),
    .kind (conf_kind)
  );

  assign asm_start = cmd_fire && rdy && ((cls == CC_SETUP) || (cls == CC_MOVE));
  assign asm_abort = cmd_fire && !asm_start;
  assign clear_all = cmd_fire && (cls == CC_RESET);

  nps_addr_asm #(.COL_W(COL_W), .ROW_W(ROW_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (asm_start),
    .abort      (asm_abort),
    .fire       (addr_fire),
    .byte_i     (in_byte),
    .collecting (collecting),
    .done       (asm_done),
    .col        (asm_col),
    .row        (asm_row)
  );

  // die and plane bits of a retarget must match the pending row
  assign mismatch =
      (asm_row[PLANE_POS] != tgt_row[PLANE_POS]) ||
      (asm_row[LUN_POS +: LUN_W] != tgt_row[LUN_POS +: LUN_W]);
  assign accept_addr = asm_done && !(chk && mismatch);

  nps_wr_stage #(.COL_W(COL_W), .COL_MAX(COL_MAX)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear_all),
    .load     (accept_addr),
    .load_col (asm_col),
    .dat_fire (data_fire && data_mode),
    .dat      (in_byte),
    .wr_ready (wr_ready),
    .ptr      (col_ptr),
    .wr_valid (wr_valid),
    .wr_col   (wr_col),
    .wr_data  (wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      chk        <= 1'b0;
      data_mode  <= 1'b0;
      tgt_row    <= '0;
      done_valid <= 1'b0;
      done_kind  <= 2'd0;
      seq_err    <= 1'b0;
      lun_err    <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      if (cmd_fire) begin
        unique case (cls)
          CC_RESET: begin
            pend      <= 1'b0;
            chk       <= 1'b0;
            data_mode <= 1'b0;
            tgt_row   <= '0;
            seq_err   <= 1'b0;
            lun_err   <= 1'b0;
          end
          CC_SETUP: begin
            if (rdy) begin
              pend      <= 1'b0;
              chk       <= 1'b0;
              data_mode <= 1'b0;
            end else begin
              seq_err <= 1'b1;
            end
          end
          CC_MOVE: begin
            if (rdy) begin
              chk       <= pend;
              data_mode <= 1'b0;
            end else begin
              seq_err <= 1'b1;
            end
          end
          CC_CONFIRM: begin
            if (pend && !collecting) begin
              done_valid <= 1'b1;
              done_kind  <= conf_kind;
              pend       <= 1'b0;
              data_mode  <= 1'b0;
            end else begin
              seq_err <= 1'b1;
            end
          end
          CC_OTHER: data_mode <= 1'b0;
          default:  seq_err   <= 1'b1;
        endcase
      end
      if (addr_fire) begin
        if (!collecting) begin
          seq_err <= 1'b1;
        end else if (asm_done) begin
          pend      <= 1'b1;
          data_mode <= 1'b1;
          if (chk && mismatch) lun_err <= 1'b1;
          else                 tgt_row <= asm_row;
        end
      end
      if (data_fire && !data_mode) seq_err <= 1'b1;
      if (bad_fire) seq_err <= 1'b1;
    end
  end
endmodule

// File: rtl/nps_pgm_seq_chk.sv
module nps_pgm_seq_chk #(
  parameter int COL_W   = 12,
  parameter int COL_MAX = 2112
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_kind,
  input logic [7:0]       in_byte,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [COL_W-1:0] wr_col,
  input logic [7:0]       wr_data,
  input logic             data_mode,
  input logic             done_valid,
  input logic [1:0]       done_kind,
  input logic             seq_err,
  input logic             lun_err
);
  logic ff_taken;
  assign ff_taken = in_valid && in_ready && (in_kind == 2'd0) && (in_byte == 8'hFF);

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_col) && $stable(wr_data))); // R1
  AST_NO_WR_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_col < COL_W'(COL_MAX))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R5
  AST_DONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_kind != 2'd0 && !data_mode)); // R5
  AST_LUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lun_err && !ff_taken) |=> lun_err); // R7
  AST_NO_WR_OUT_OF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind == 2'd2 && !data_mode) |=> !wr_valid); // R11
  AST_SEQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && !ff_taken) |=> seq_err); // R11
endmodule

bind nps_pgm_seq nps_pgm_seq_chk #(.COL_W(COL_W), .COL_MAX(COL_MAX)) u_chk (.*);

// File: tb/sim_nps_pgm_seq.sv
module sim_nps_pgm_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rdy = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_kind = 2'd0;
  logic [7:0]  in_byte = 8'h00;
  logic        wr_ready = 1'b1;
  logic        in_ready, wr_valid, data_mode, done_valid, seq_err, lun_err;
  logic [11:0] wr_col, col_ptr;
  logic [7:0]  wr_data;
  logic [23:0] tgt_row;
  logic [1:0]  done_kind;
  int nchk = 0;
  int nfail = 0;

  localparam logic [1:0] K_CMD = 2'd0, K_ADDR = 2'd1, K_DATA = 2'd2, K_BAD = 2'd3;

  always #4 clk = ~clk;

  nps_pgm_seq u0 (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_byte(in_byte), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_col(wr_col), .wr_data(wr_data), .col_ptr(col_ptr), .tgt_row(tgt_row),
    .data_mode(data_mode), .done_valid(done_valid), .done_kind(done_kind),
    .seq_err(seq_err), .lun_err(lun_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic addr5(input logic [11:0] col, input logic [23:0] row);
    cyc(K_ADDR, col[7:0]);
    cyc(K_ADDR, {4'h0, col[11:8]});
    cyc(K_ADDR, row[7:0]);
    cyc(K_ADDR, row[15:8]);
    cyc(K_ADDR, row[23:16]);
  endtask

  task automatic t_reset;
    check("R12 data_mode", data_mode, 0);
    check("R12 seq_err", seq_err, 0);
    check("R12 lun_err", lun_err, 0);
    check("R12 col_ptr", col_ptr, 0);
    check("R12 tgt_row", tgt_row, 0);
    check("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_basic;
    cyc(K_CMD, 8'hFF);
    cyc(K_CMD, 8'h80);
    cyc(K_ADDR, 8'h23); cyc(K_ADDR, 8'h01); cyc(K_ADDR, 8'h45); cyc(K_ADDR, 8'h0A);
    check("R2 mode before fifth", data_mode, 0);
    cyc(K_ADDR, 8'h00);
    check("R2 data_mode", data_mode, 1);
    check("R2 col_ptr", col_ptr, 12'h123);
    check("R2 tgt_row", tgt_row, 24'h000A45);
    cyc(K_DATA, 8'h5A);
    check("R3 wr_valid", wr_valid, 1);
    check("R3 wr_col", wr_col, 12'h123);
    check("R3 wr_data", wr_data, 8'h5A);
    check("R3 col_ptr", col_ptr, 12'h124);
    cyc(K_DATA, 8'h3C);
    check("R3 wr_col 2", wr_col, 12'h124);
    cyc(K_CMD, 8'h10);
    check("R5 done_valid", done_valid, 1);
    check("R5 done_kind", done_kind, 1);
    check("R5 data_mode off", data_mode, 0);
    check("R5 no error", seq_err, 0);
    @(negedge clk);
    check("R5 pulse ends", done_valid, 0);
  endtask

  task automatic t_kinds;
    cyc(K_CMD, 8'h80); addr5(12'h000, 24'h000100);
    cyc(K_CMD, 8'h11);
    check("R5 two-plane kind", done_kind, 2);
    cyc(K_CMD, 8'h80); addr5(12'h000, 24'h000200);
    cyc(K_CMD, 8'h15);
    check("R5 cache kind", done_kind, 3);
    check("R5 cache done", done_valid, 1);
  endtask

  task automatic t_retarget;
    cyc(K_CMD, 8'hFF);
    cyc(K_CMD, 8'h80); addr5(12'h010, 24'h800040);
    cyc(K_DATA, 8'hAA);
    check("R3 first col", wr_col, 12'h010);
    cyc(K_CMD, 8'h85); addr5(12'h200, 24'h8000C3);
    check("R6 data_mode", data_mode, 1);
    check("R6 tgt_row", tgt_row, 24'h8000C3);
    check("R6 col_ptr", col_ptr, 12'h200);
    check("R6 lun_err", lun_err, 0);
    cyc(K_DATA, 8'h55);
    check("R6 new col write", wr_col, 12'h200);
    cyc(K_CMD, 8'h10);
    check("R6 confirm", done_valid, 1);
  endtask

  task automatic t_mismatch;
    cyc(K_CMD, 8'hFF);
    cyc(K_CMD, 8'h80); addr5(12'h020, 24'h000040);
    cyc(K_DATA, 8'h01);
    cyc(K_CMD, 8'h85); addr5(12'h300, 24'h000005);
    check("R7 lun_err plane", lun_err, 1);
    check("R7 tgt_row kept", tgt_row, 24'h000040);
    check("R7 col_ptr kept", col_ptr, 12'h021);
    check("R7 data_mode", data_mode, 1);
    cyc(K_CMD, 8'h05);
    check("R7 sticky", lun_err, 1);
    cyc(K_CMD, 8'hFF);
    check("R12 lun_err cleared", lun_err, 0);
    cyc(K_CMD, 8'h80); addr5(12'h000, 24'h000000);
    cyc(K_CMD, 8'h85); addr5(12'h000, 24'h800000);
    check("R7 lun_err die", lun_err, 1);
  endtask

  task automatic t_idle85;
    cyc(K_CMD, 8'hFF);
    cyc(K_CMD, 8'h85); addr5(12'h007, 24'h800123);
    check("R8 data_mode", data_mode, 1);
    check("R8 no lun_err", lun_err, 0);
    check("R8 tgt_row", tgt_row, 24'h800123);
    check("R8 col_ptr", col_ptr, 12'h007);
    cyc(K_CMD, 8'h15);
    check("R8 done kind", done_kind, 3);
  endtask

  task automatic t_busy;
    cyc(K_CMD, 8'hFF);
    cyc(K_CMD, 8'h80); addr5(12'h040, 24'h000011);
    rdy = 1'b0;
    cyc(K_CMD, 8'h85);
    check("R9 seq_err", seq_err, 1);
    check("R9 data_mode kept", data_mode, 1);
    check("R9 col_ptr kept", col_ptr, 12'h040);
    rdy = 1'b1;
    cyc(K_CMD, 8'hFF);
    rdy = 1'b0;
    cyc(K_CMD, 8'h80);
    rdy = 1'b1;
    check("R9 setup busy", seq_err, 1);
    cyc(K_ADDR, 8'h00);
    check("R9 no collection", data_mode, 0);
  endtask

  task automatic t_other;
    cyc(K_CMD, 8'hFF);
    cyc(K_CMD, 8'h80); addr5(12'h005, 24'h000022);
    cyc(K_CMD, 8'h05);
    check("R10 mode ends", data_mode, 0);
    check("R10 no error", seq_err, 0);
    cyc(K_DATA, 8'h77);
    check("R11 data outside mode", seq_err, 1);
    check("R11 no write", wr_valid, 0);
    cyc(K_CMD, 8'hE0);
    cyc(K_CMD, 8'h10);
    check("R10 pending kept", done_valid, 1);
    check("R11 sticky", seq_err, 1);
  endtask

  task automatic t_errors;
    cyc(K_CMD, 8'hFF);
    cyc(K_CMD, 8'h10);
    check("R11 confirm idle", seq_err, 1);
    check("R11 confirm no done", done_valid, 0);
    cyc(K_CMD, 8'hFF);
    cyc(K_CMD, 8'h42);
    check("R11 unknown", seq_err, 1);
    cyc(K_CMD, 8'hFF);
    cyc(K_ADDR, 8'h12);
    check("R11 stray address", seq_err, 1);
    cyc(K_CMD, 8'hFF);
    cyc(K_BAD, 8'h00);
    check("R11 kind 3", seq_err, 1);
    cyc(K_CMD, 8'hFF);
    check("R12 seq_err cleared", seq_err, 0);
  endtask

  task automatic t_saturate;
    cyc(K_CMD, 8'hFF);
    cyc(K_CMD, 8'h80); addr5(12'h83E, 24'h0);
    cyc(K_DATA, 8'h01);
    check("R4 col 2110", wr_col, 12'd2110);
    cyc(K_DATA, 8'h02);
    check("R4 col 2111", wr_col, 12'd2111);
    check("R4 ptr at end", col_ptr, 12'd2112);
    cyc(K_DATA, 8'h03);
    check("R4 no write at end", wr_valid, 0);
    check("R4 ptr held", col_ptr, 12'd2112);
    check("R4 no error", seq_err, 0);
    cyc(K_CMD, 8'h85); addr5(12'hFFF, 24'h0);
    check("R4 clamp", col_ptr, 12'd2112);
  endtask

  task automatic t_backpressure;
    cyc(K_CMD, 8'hFF);
    cyc(K_CMD, 8'h80); addr5(12'h000, 24'h0);
    wr_ready = 1'b0;
    cyc(K_DATA, 8'h11);
    check("R1 write held", wr_valid, 1);
    check("R1 in_ready low", in_ready, 0);
    in_valid = 1'b1; in_kind = K_DATA; in_byte = 8'h22;
    @(negedge clk);
    check("R1 col stable", wr_col, 12'h000);
    check("R1 data stable", wr_data, 8'h11);
    check("R1 not taken", col_ptr, 12'h001);
    wr_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 next write col", wr_col, 12'h001);
    check("R1 next write data", wr_data, 8'h22);
    check("R1 ptr", col_ptr, 12'h002);
    @(negedge clk);
    check("R1 drained", wr_valid, 0);
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_kinds;
    t_retarget;
    t_mismatch;
    t_idle85;
    t_busy;
    t_other;
    t_errors;
    t_saturate;
    t_backpressure;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule